// File: doc/BRIEF.md
# Time-Stamp Reorder Buffer

This block takes frames of station samples from a network receiver and files each one into an on-chip circular store at a position chosen by the frame's time stamp, not by when it arrived. Network delay is absorbed this way, and frames that arrive out of order are put back into time order. Each frame carries a stream index, which stands for one station and sub-band pair, and a time stamp in units of whole frames. Each beat of a frame holds one sample from each of the two polarizations. Samples narrower than a byte are zero-extended to 8 bits before storage.

A free-running correlator time count drives the read side. Once the correlator time is at least `DELAY` frame periods past a time slot, that slot is read out. The read goes stream by stream in ascending order, each frame as `FRAME_LEN` beats. If no frame arrived for a stream and slot, the block still emits the frame at its usual place in the sequence, with the data forced to zero and the frame-good flag low. A frame whose time stamp falls outside the writable window is consumed and dropped, and a wrapping counter records each drop.

Both data interfaces are valid/ready. A beat moves when valid and ready are both high at a rising clock edge. On the input, `in_ready` goes low only in the cycle in which the reader begins a new time slot. The sender must then hold its beat until `in_ready` returns. On the output, `out_valid` stays high and every `out_*` field stays stable for as long as `out_ready` is low.

Top module: `reorder_buffer`

## Requirements
- R1: After reset, `out_valid` is 0, `drop_count` is 0, `in_ready` is 1 while the first slot is not yet due, and the read position is time 0.
- R2: A frame is exactly `FRAME_LEN` accepted input beats, and `in_stream` and `in_ts` are taken only from the first beat. `in_ready` is 1 whenever the reader is not starting a slot in that cycle.
- R3: Each output beat packs polarization A zero-extended into `out_data[7:0]` and polarization B zero-extended into `out_data[15:8]`.
- R4: A frame with time stamp t is stored in slot t mod `NSLOT` and is read back at the readout of time t, whatever order the frames arrived in.
- R5: The readout of time t starts only once `corr_time - t` (mod 2^TW) is at least `DELAY`. It emits streams 0 to `NSTREAM-1` in order, each as `FRAME_LEN` beats with `out_ts` = t and `out_last` high on that frame's final beat.
- R6: A stream with no frame stored for the slot being read is emitted with `out_ok` = 0 and `out_data` = 0 on every beat.
- R7: Reading a slot clears its stored-frame flag, so a slot that is not rewritten before its next lap is reported with `out_ok` = 0.
- R8: A frame is kept only if `(in_ts - read position) mod 2^TW < NSLOT`. Otherwise all of its beats are consumed without effect and `drop_count` increases by one.
- R9: A frame whose time stamp equals the read position while that slot is being read out is dropped and counted, like an out-of-window frame.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_stream`, `out_ts`, `out_data`, `out_ok` and `out_last` stay unchanged.
- R11: A second frame for the same stream and time stamp, arriving before that slot is read, replaces the first one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| corr_time | input | TW | Correlator time in frame periods |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted |
| in_stream | input | SIDW | Station/sub-band index (first beat) |
| in_ts | input | TW | Frame time stamp (first beat) |
| in_pol_a | input | SW | Polarization A sample |
| in_pol_b | input | SW | Polarization B sample |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Output beat taken |
| out_data | output | 16 | Packed padded samples, B high byte, A low byte |
| out_stream | output | SIDW | Stream of current frame |
| out_ts | output | TW | Time slot being read |
| out_ok | output | 1 | Frame was received |
| out_last | output | 1 | Final beat of the frame |
| drop_count | output | CW | Frames dropped, wrapping |

## Verification
Random rounds send a few frames per read slot. Their time offsets run from two slots late to beyond the window end, so the stream is a mix of in-order, out-of-order, duplicate, late and too-early frames, and the test tells correct timestamp placement apart from placement by arrival order and from a faulty window test. Many slots receive nothing, so missing frames show up as zero data with the flag low, and stale data left from an earlier lap is caught. The run covers more than 256 slots, which wraps the time stamps. A random `out_ready` pattern exercises output stalls. One directed case holds the reader inside a slot and then offers frames both for that slot and for a later one, which separates the rule for the slot under readout from the plain window check.

// File: rtl/reorder_pkg.sv
package reorder_pkg;
  // Index width for a count of items, at least one bit.
  function automatic int unsigned idx_w(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/reorder_wr_ctl.sv
module reorder_wr_ctl
  import reorder_pkg::*;
#(
  parameter int TW      = 8,
  parameter int NSLOT   = 8,
  parameter int NSTREAM = 2,
  parameter int FLEN    = 4,
  parameter int CW      = 16,
  localparam int SLW    = idx_w(NSLOT),
  localparam int SIDW   = idx_w(NSTREAM),
  localparam int BW     = idx_w(FLEN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [SIDW-1:0] in_stream,
  input  logic [TW-1:0]   in_ts,
  input  logic [TW-1:0]   rd_ts,
  input  logic            rd_busy,
  input  logic            rd_start,
  output logic            wr_en,
  output logic            wr_done,
  output logic            wr_busy,
  output logic [SIDW-1:0] wr_stream,
  output logic [SLW-1:0]  wr_slot,
  output logic [BW-1:0]   wr_beat,
  output logic [CW-1:0]   drop_count
);
  logic [BW-1:0]   beat_q;
  logic            keep_q;
  logic [SIDW-1:0] stream_q;
  logic [SLW-1:0]  slot_q;
  logic [TW-1:0]   ahead;
  logic            first, fire, accept, keep_now, last;

  assign in_ready = !rd_start;
  assign fire     = in_valid && in_ready;
  assign first    = (beat_q == '0);
  assign last     = (beat_q == BW'(FLEN - 1));
  assign ahead    = in_ts - rd_ts;
  assign accept   = (ahead < TW'(NSLOT)) && !((ahead == '0) && rd_busy);
  assign keep_now = first ? accept : keep_q;

  assign wr_stream = first ? in_stream : stream_q;
  assign wr_slot   = first ? in_ts[SLW-1:0] : slot_q;
  assign wr_beat   = beat_q;
  assign wr_en     = fire && keep_now;
  assign wr_done   = wr_en && last;
  assign wr_busy   = !first;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat_q     <= '0;
      keep_q     <= 1'b0;
      stream_q   <= '0;
      slot_q     <= '0;
      drop_count <= '0;
    end else if (fire) begin
      beat_q <= last ? '0 : beat_q + 1'b1;
      if (first) begin
        keep_q   <= accept;
        stream_q <= in_stream;
        slot_q   <= in_ts[SLW-1:0];
        if (!accept) drop_count <= drop_count + 1'b1;
      end
    end
  end

  // R8
  drop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (drop_count == $past(drop_count)) || (drop_count == $past(drop_count) + 1'b1));
  // R9
  no_live_slot_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && first && rd_busy && (in_ts == rd_ts)) |=> (drop_count == $past(drop_count) + 1'b1));
endmodule

// File: rtl/reorder_rd_ctl.sv
module reorder_rd_ctl
  import reorder_pkg::*;
#(
  parameter int TW      = 8,
  parameter int NSTREAM = 2,
  parameter int FLEN    = 4,
  parameter int DELAY   = 4,
  localparam int SIDW   = idx_w(NSTREAM),
  localparam int BW     = idx_w(FLEN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TW-1:0]   corr_time,
  input  logic            wr_busy,
  input  logic            out_ready,
  output logic            rd_start,
  output logic            rd_busy,
  output logic            rd_done,
  output logic            out_valid,
  output logic            out_last,
  output logic [TW-1:0]   rd_ts,
  output logic [SIDW-1:0] rd_stream,
  output logic [BW-1:0]   rd_beat
);
  logic [TW-1:0] lag;
  logic          due, step, last_beat, last_stream;

  assign lag         = corr_time - rd_ts;
  assign due         = (lag >= TW'(DELAY));
  assign rd_start    = !rd_busy && due && !wr_busy;
  assign out_valid   = rd_busy;
  assign step        = rd_busy && out_ready;
  assign last_beat   = (rd_beat == BW'(FLEN - 1));
  assign last_stream = (rd_stream == SIDW'(NSTREAM - 1));
  assign out_last    = rd_busy && last_beat;
  assign rd_done     = step && last_beat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_busy   <= 1'b0;
      rd_ts     <= '0;
      rd_stream <= '0;
      rd_beat   <= '0;
    end else if (rd_start) begin
      rd_busy <= 1'b1;
    end else if (step) begin
      if (!last_beat) begin
        rd_beat <= rd_beat + 1'b1;
      end else begin
        rd_beat <= '0;
        if (last_stream) begin
          rd_stream <= '0;
          rd_busy   <= 1'b0;
          rd_ts     <= rd_ts + 1'b1;
        end else begin
          rd_stream <= rd_stream + 1'b1;
        end
      end
    end
  end

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(rd_stream) && $stable(rd_beat) && $stable(rd_ts));
endmodule

// File: rtl/reorder_store.sv
module reorder_store
  import reorder_pkg::*;
#(
  parameter int NSLOT   = 8,
  parameter int NSTREAM = 2,
  parameter int FLEN    = 4,
  parameter int SW      = 4,
  localparam int SLW    = idx_w(NSLOT),
  localparam int SIDW   = idx_w(NSTREAM),
  localparam int BW     = idx_w(FLEN),
  localparam int FW     = SIDW + SLW,
  localparam int NFLAG  = 1 << FW,
  localparam int DEPTH  = 1 << (FW + BW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            set_en,
  input  logic [SIDW-1:0] wr_stream,
  input  logic [SLW-1:0]  wr_slot,
  input  logic [BW-1:0]   wr_beat,
  input  logic [SW-1:0]   pol_a,
  input  logic [SW-1:0]   pol_b,
  input  logic            clr_en,
  input  logic [SIDW-1:0] rd_stream,
  input  logic [SLW-1:0]  rd_slot,
  input  logic [BW-1:0]   rd_beat,
  output logic [15:0]     rd_word,
  output logic            rd_ok
);
  logic [15:0]      mem [DEPTH];
  logic [NFLAG-1:0] have_q;
  logic [FW-1:0]    set_idx, clr_idx;
  logic [7:0]       pad_a, pad_b;

  assign pad_a   = 8'(pol_a);
  assign pad_b   = 8'(pol_b);
  assign set_idx = {wr_stream, wr_slot};
  assign clr_idx = {rd_stream, rd_slot};

  always_ff @(posedge clk) begin
    if (wr_en) mem[{set_idx, wr_beat}] <= {pad_b, pad_a};
  end

  for (genvar f = 0; f < NFLAG; f++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)                                have_q[f] <= 1'b0;
      else if (set_en && (set_idx == FW'(f)))    have_q[f] <= 1'b1;
      else if (clr_en && (clr_idx == FW'(f)))    have_q[f] <= 1'b0;
    end
  end

  assign rd_ok   = have_q[clr_idx];
  assign rd_word = mem[{clr_idx, rd_beat}];

  // R7
  flag_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_en && clr_en && (set_idx == clr_idx)));
  // R7
  flag_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !set_en) |=> !have_q[$past(clr_idx)]);
endmodule

// File: rtl/reorder_buffer.sv
module reorder_buffer
  import reorder_pkg::*;
#(
  parameter int TW      = 8,
  parameter int NSLOT   = 8,
  parameter int NSTREAM = 2,
  parameter int FLEN    = 4,
  parameter int DELAY   = 4,
  parameter int SW      = 4,
  parameter int CW      = 16,
  localparam int SLW    = idx_w(NSLOT),
  localparam int SIDW   = idx_w(NSTREAM),
  localparam int BW     = idx_w(FLEN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TW-1:0]   corr_time,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [SIDW-1:0] in_stream,
  input  logic [TW-1:0]   in_ts,
  input  logic [SW-1:0]   in_pol_a,
  input  logic [SW-1:0]   in_pol_b,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [15:0]     out_data,
  output logic [SIDW-1:0] out_stream,
  output logic [TW-1:0]   out_ts,
  output logic            out_ok,
  output logic            out_last,
  output logic [CW-1:0]   drop_count
);
  logic            rd_start, rd_busy, rd_done;
  logic [TW-1:0]   rd_ts;
  logic [SIDW-1:0] rd_stream;
  logic [BW-1:0]   rd_beat;
  logic            wr_en, wr_done, wr_busy;
  logic [SIDW-1:0] wr_stream;
  logic [SLW-1:0]  wr_slot;
  logic [BW-1:0]   wr_beat;
  logic [15:0]     rd_word;
  logic            rd_ok;

  reorder_wr_ctl #(.TW(TW), .NSLOT(NSLOT), .NSTREAM(NSTREAM), .FLEN(FLEN), .CW(CW)) u_wr (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_stream(in_stream), .in_ts(in_ts), .rd_ts(rd_ts), .rd_busy(rd_busy),
    .rd_start(rd_start), .wr_en(wr_en), .wr_done(wr_done), .wr_busy(wr_busy),
    .wr_stream(wr_stream), .wr_slot(wr_slot), .wr_beat(wr_beat), .drop_count(drop_count));

  reorder_rd_ctl #(.TW(TW), .NSTREAM(NSTREAM), .FLEN(FLEN), .DELAY(DELAY)) u_rd (
    .clk(clk), .rst_n(rst_n), .corr_time(corr_time), .wr_busy(wr_busy),
    .out_ready(out_ready), .rd_start(rd_start), .rd_busy(rd_busy), .rd_done(rd_done),
    .out_valid(out_valid), .out_last(out_last), .rd_ts(rd_ts),
    .rd_stream(rd_stream), .rd_beat(rd_beat));

  reorder_store #(.NSLOT(NSLOT), .NSTREAM(NSTREAM), .FLEN(FLEN), .SW(SW)) u_mem (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .set_en(wr_done),
    .wr_stream(wr_stream), .wr_slot(wr_slot), .wr_beat(wr_beat),
    .pol_a(in_pol_a), .pol_b(in_pol_b), .clr_en(rd_done),
    .rd_stream(rd_stream), .rd_slot(rd_ts[SLW-1:0]), .rd_beat(rd_beat),
    .rd_word(rd_word), .rd_ok(rd_ok));

  assign out_data   = rd_ok ? rd_word : 16'h0;
  assign out_ok     = rd_ok;
  assign out_stream = rd_stream;
  assign out_ts     = rd_ts;

  // R4
  no_write_into_read_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rd_busy && (wr_slot == rd_ts[SLW-1:0])));
  // R5
  read_not_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_busy) |-> (TW'($past(corr_time) - rd_ts) >= TW'(DELAY)));
  // R6
  missing_is_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ok) |-> (out_data == 16'h0));
endmodule

// File: tb/reorder_buffer_bench.sv
module reorder_buffer_bench;
  localparam int TW = 8, NSLOT = 8, NSTREAM = 2, FLEN = 4, DELAY = 4, SW = 4, CW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [TW-1:0] corr_time;
  logic in_valid, in_ready, out_valid, out_ready, out_ok, out_last;
  logic [0:0] in_stream, out_stream;
  logic [TW-1:0] in_ts, out_ts;
  logic [SW-1:0] in_pol_a, in_pol_b;
  logic [15:0] out_data;
  logic [CW-1:0] drop_count;

  always #10 clk = ~clk;

  reorder_buffer u_reorder_buffer (
    .clk(clk), .rst_n(rst_n), .corr_time(corr_time), .in_valid(in_valid), .in_ready(in_ready),
    .in_stream(in_stream), .in_ts(in_ts), .in_pol_a(in_pol_a), .in_pol_b(in_pol_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_stream(out_stream),
    .out_ts(out_ts), .out_ok(out_ok), .out_last(out_last), .drop_count(drop_count));

  int checks = 0, failures = 0, exp_drops = 0, rd_pos = 0;
  logic [15:0] exp_data [NSTREAM][NSLOT][FLEN];
  bit exp_have [NSTREAM][NSLOT];
  bit done = 1'b0;

  function automatic logic [15:0] pack(logic [SW-1:0] a, logic [SW-1:0] b);
    return {4'h0, b, 4'h0, a};
  endfunction

  function automatic int ahead_of(int ts, int pos);
    return (ts - pos) & 255;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_frame(int s, int ts, bit reader_busy);
    int a = ahead_of(ts, rd_pos);
    bit keep = (a < NSLOT) && !(a == 0 && reader_busy);
    bit rdy;
    if (!keep) exp_drops++;
    check(in_ready == 1'b1, "R2 in_ready idle", int'(in_ready), 1);
    for (int b = 0; b < FLEN; b++) begin
      logic [SW-1:0] pa = SW'($urandom);
      logic [SW-1:0] pb = SW'($urandom);
      in_valid  = 1'b1;
      in_stream = (b == 0) ? 1'(s) : 1'($urandom);
      in_ts     = (b == 0) ? 8'(ts) : 8'($urandom);
      in_pol_a  = pa;
      in_pol_b  = pb;
      if (keep) exp_data[s][ts % NSLOT][b] = pack(pa, pb);
      forever begin
        rdy = in_ready;
        @(negedge clk);
        if (rdy) break;
      end
    end
    in_valid = 1'b0;
    if (keep) exp_have[s][ts % NSLOT] = 1'b1;
  endtask

  task automatic read_slot(bit rand_ready);
    int cnt = 0;
    int slot = rd_pos % NSLOT;
    bit stall = 1'b0;
    logic [15:0] s_data;
    logic [0:0] s_str;
    while (cnt < NSTREAM * FLEN) begin
      if (stall) begin
        check(out_valid && out_data == s_data && out_stream == s_str, "R10 hold",
              int'(out_data), int'(s_data));
      end
      out_ready = rand_ready ? ($urandom % 4 != 0) : 1'b1;
      stall = out_valid && !out_ready;
      s_data = out_data;
      s_str  = out_stream;
      if (out_valid && out_ready) begin
        int s = cnt / FLEN;
        int b = cnt % FLEN;
        logic [15:0] ed = exp_have[s][slot] ? exp_data[s][slot][b] : 16'h0;
        check(out_stream == 1'(s), "R5 stream order", int'(out_stream), s);
        check(out_ts == 8'(rd_pos), "R5 out_ts", int'(out_ts), rd_pos);
        check(out_last == (b == FLEN - 1), "R5 out_last", int'(out_last), int'(b == FLEN - 1));
        check(out_ok == exp_have[s][slot], "R6/R7 out_ok", int'(out_ok), int'(exp_have[s][slot]));
        check(out_data == ed, "R3/R4/R11 data", int'(out_data), int'(ed));
        cnt++;
      end
      @(negedge clk);
    end
    out_ready = 1'b0;
    for (int s = 0; s < NSTREAM; s++) exp_have[s][slot] = 1'b0;
    rd_pos = (rd_pos + 1) & 255;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    process::self().srandom(32'd1234);
    in_valid = 1'b0; out_ready = 1'b0; in_stream = '0; in_ts = '0;
    in_pol_a = '0; in_pol_b = '0; corr_time = 8'(DELAY - 1);
    for (int s = 0; s < NSTREAM; s++) for (int k = 0; k < NSLOT; k++) exp_have[s][k] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    check(drop_count == '0, "R1 drop_count", int'(drop_count), 0);
    check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);

    // R4 out-of-order arrival, R8 early and late frames, R11 duplicate
    send_frame(0, 2, 1'b0);
    send_frame(1, 0, 1'b0);
    send_frame(0, 1, 1'b0);
    send_frame(0, 0, 1'b0);
    send_frame(1, 0, 1'b0);
    send_frame(1, 9, 1'b0);
    send_frame(0, 255, 1'b0);
    check(int'(drop_count) == exp_drops, "R8 drops", int'(drop_count), exp_drops);

    for (int it = 0; it < 300; it++) begin
      int n = $urandom % 4;
      for (int f = 0; f < n; f++) begin
        int off = int'($urandom % 12) - 2;
        send_frame(int'($urandom % NSTREAM), (rd_pos + off) & 255, 1'b0);
      end
      corr_time = 8'(rd_pos + DELAY);
      if (it == 150) begin
        // R9: frame for the slot under readout is dropped, a later one kept
        while (!out_valid) @(negedge clk);
        send_frame(NSTREAM - 1, rd_pos, 1'b1);
        send_frame(0, (rd_pos + 3) & 255, 1'b1);
        check(int'(drop_count) == exp_drops, "R9 drops", int'(drop_count), exp_drops);
      end
      read_slot(1'b1);
      check(int'(drop_count) == exp_drops, "R8 drops", int'(drop_count), exp_drops);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule